// File: doc/BRIEF.md
# Triggered Multi-Channel Snapshot Reader

This block collects one coherent set of sensor readings each time it is triggered. Seven channels exist, indexed by a fixed order: index 0 is the temperature channel, indices 1 to 3 are the three acceleration axes (X, Y, Z), and indices 4 to 6 are the three angular-rate axes (X, Y, Z). A 7-bit enable mask selects which channels take part. For each enabled channel, the block issues one read on a single-outstanding register-read port. It skips disabled channels without touching the port.

The first read of every burst raises a capture flag, which tells the device to freeze a consistent snapshot. Every later read in the same burst keeps the flag low, so all reads return values from the same frozen snapshot.

Results are held locally until the last read returns. They are then streamed out one per cycle, packed without gaps in index order, with a marker on the final word. If any read response reports an error, the whole burst is discarded and nothing is streamed. A trigger that arrives while a burst is still running is dropped, and the block reports an overrun pulse instead.

Top module: `cap_reader`

## Requirements
- R1: Enabled channels are read in ascending index order: index 0 is temperature, indices 1 to 3 are acceleration X/Y/Z, and indices 4 to 6 are angular rate X/Y/Z. A disabled channel produces no read request. Each request is a single-cycle `rd_req_valid` pulse that first appears in the cycle after the trigger is sampled, and again in the cycle after each successful response.
- R2: The read address for channel index i is 0x17 + i.
- R3: `rd_capture` is 1 on the first request of a burst and 0 on every later request of that burst.
- R4: After a successful final response, the samples appear from the next cycle onward, one per cycle with `smp_valid` high. They are packed in index order, each 16-bit signed value passed unchanged, and `smp_last` is high only on the final sample.
- R5: An error response ends the burst at once. No sample of that burst is output, and the block accepts a new trigger from the next cycle.
- R6: A trigger with an all-zero mask produces no request and no sample, and the block stays ready for the next trigger.
- R7: A trigger sampled while a burst is requesting, waiting or streaming is dropped. `overrun` goes high for exactly the following cycle.
- R8: After synchronous reset, `rd_req_valid`, `smp_valid`, `smp_last` and `overrun` are all 0.
- R9: A response that arrives when no request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Start-of-burst pulse |
| ch_en | input | 7 | Channel enable mask, bit i enables index i |
| rd_req_valid | output | 1 | Read request strobe |
| rd_addr | output | 8 | Read register address |
| rd_capture | output | 1 | Snapshot capture flag on the request |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_err | input | 1 | Response carries an error |
| rd_rsp_data | input | 16 | Response data word |
| smp_valid | output | 1 | Output sample strobe |
| smp_data | output | 16 | Output sample, signed |
| smp_last | output | 1 | Final sample of the burst |
| overrun | output | 1 | Trigger dropped while busy |

## Verification
The assertions assume that the responder returns exactly one response per request, no earlier than the cycle after the request strobe. The capture-flag and error-discard checks track outstanding reads from that assumption. The bench responder keeps within it: it waits a chosen latency of one to four cycles after it sees a request before answering. Its only out-of-turn responses are deliberate stray pulses, and these are sent while the block is idle.

// File: rtl/cap_pkg.sv
package cap_pkg;

    parameter int          CAP_NCH  = 7;
    parameter int          CAP_DW   = 16;
    parameter int          CAP_AW   = 8;
    parameter logic [7:0]  CAP_BASE = 8'h17;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DRAIN = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic vld;
        logic err;
    } rsp_flags_t;

endpackage

// File: rtl/cap_pick.sv
module cap_pick #(
    parameter int N  = 7,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cap_buf.sv
module cap_buf #(
    parameter int N  = 7,
    parameter int DW = 16,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_ptr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] slot [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr == PW'(g)) slot[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_ptr == PW'(i)) rd_data = slot[i];
        end
    end
endmodule

// File: rtl/cap_reader.sv
module cap_reader
    import cap_pkg::*;
#(
    parameter int              NCH  = CAP_NCH,
    parameter int              DW   = CAP_DW,
    parameter int              AW   = CAP_AW,
    parameter logic [AW-1:0]   BASE = CAP_BASE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           trig,
    input  logic [NCH-1:0] ch_en,
    output logic           rd_req_valid,
    output logic [AW-1:0]  rd_addr,
    output logic           rd_capture,
    input  logic           rd_rsp_valid,
    input  logic           rd_rsp_err,
    input  logic [DW-1:0]  rd_rsp_data,
    output logic           smp_valid,
    output logic [DW-1:0]  smp_data,
    output logic           smp_last,
    output logic           overrun
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CW = $clog2(NCH + 1);

    cap_state_e     st;
    logic [NCH-1:0] pend;
    logic [NCH-1:0] pend_clr;
    logic           first;
    logic [CW-1:0]  wcnt;
    logic [CW-1:0]  rptr;
    logic [IW-1:0]  cur;
    logic           ovr_q;
    rsp_flags_t     rsp;
    logic           store;

    assign rsp.vld = rd_rsp_valid;
    assign rsp.err = rd_rsp_err;

    cap_pick #(.N(NCH), .IW(IW)) i_pick (
        .vec (pend),
        .idx (cur)
    );

    assign pend_clr = pend & ~(NCH'(1) << cur);
    assign store    = (st == ST_WAIT) && rsp.vld && !rsp.err;

    cap_buf #(.N(NCH), .DW(DW), .PW(CW)) i_buf (
        .clk     (clk),
        .wr_en   (store),
        .wr_ptr  (wcnt),
        .wr_data (rd_rsp_data),
        .rd_ptr  (rptr),
        .rd_data (smp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            pend  <= '0;
            first <= 1'b0;
            wcnt  <= '0;
            rptr  <= '0;
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= trig && (st != ST_IDLE);
            case (st)
                ST_IDLE: begin
                    if (trig && (|ch_en)) begin
                        pend  <= ch_en;
                        first <= 1'b1;
                        wcnt  <= '0;
                        st    <= ST_REQ;
                    end
                end
                ST_REQ: st <= ST_WAIT;
                ST_WAIT: begin
                    if (rsp.vld) begin
                        if (rsp.err) begin
                            st <= ST_IDLE;
                        end else begin
                            pend  <= pend_clr;
                            first <= 1'b0;
                            wcnt  <= wcnt + CW'(1);
                            if (pend_clr == '0) begin
                                rptr <= '0;
                                st   <= ST_DRAIN;
                            end else begin
                                st <= ST_REQ;
                            end
                        end
                    end
                end
                ST_DRAIN: begin
                    rptr <= rptr + CW'(1);
                    if (smp_last) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign rd_req_valid = (st == ST_REQ);
    assign rd_addr      = BASE + AW'(cur);
    assign rd_capture   = (st == ST_REQ) && first;
    assign smp_valid    = (st == ST_DRAIN);
    assign smp_last     = (st == ST_DRAIN) && (rptr == wcnt - CW'(1));
    assign overrun      = ovr_q;
endmodule

// File: rtl/cap_reader_chk.sv
module cap_reader_chk #(
    parameter int            NCH  = 7,
    parameter int            AW   = 8,
    parameter logic [AW-1:0] BASE = 8'h17
) (
    input logic          clk,
    input logic          rst,
    input logic          trig,
    input logic          rd_req_valid,
    input logic [AW-1:0] rd_addr,
    input logic          rd_capture,
    input logic          rd_rsp_valid,
    input logic          rd_rsp_err,
    input logic          smp_valid,
    input logic          smp_last,
    input logic          overrun
);
    localparam logic [AW-1:0] TOP = BASE + AW'(NCH - 1);

    logic outst;
    logic in_burst;

    always_ff @(posedge clk) begin
        if (rst) begin
            outst    <= 1'b0;
            in_burst <= 1'b0;
        end else begin
            if (rd_req_valid) outst <= 1'b1;
            else if (rd_rsp_valid) outst <= 1'b0;
            if (rd_req_valid) in_burst <= 1'b1;
            else if ((smp_valid && smp_last) || (outst && rd_rsp_valid && rd_rsp_err))
                in_burst <= 1'b0;
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |=> !rd_req_valid);                                   // R1
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> (rd_addr >= BASE && rd_addr <= TOP));             // R2
    AST_CAP_FIRST: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !in_burst) |-> rd_capture);                       // R3
    AST_CAP_LATER: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && in_burst) |-> !rd_capture);                       // R3
    AST_CAP_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
        rd_capture |-> rd_req_valid);                                      // R3
    AST_LAST_IN_STREAM: assert property (@(posedge clk) disable iff (rst)
        smp_last |-> smp_valid);                                           // R4
    AST_STREAM_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> !rd_req_valid);                                      // R4
    AST_ERR_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (outst && rd_rsp_valid && rd_rsp_err) |=> !smp_valid);             // R5
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(trig));                                          // R7
endmodule

bind cap_reader cap_reader_chk #(.NCH(NCH), .AW(AW), .BASE(BASE)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .trig         (trig),
    .rd_req_valid (rd_req_valid),
    .rd_addr      (rd_addr),
    .rd_capture   (rd_capture),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_err   (rd_rsp_err),
    .smp_valid    (smp_valid),
    .smp_last     (smp_last),
    .overrun      (overrun)
);

// File: tb/test_cap_reader.sv
module test_cap_reader;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [6:0]  ch_en = '0;
    logic        rd_req_valid;
    logic [7:0]  rd_addr;
    logic        rd_capture;
    logic        rd_rsp_valid = 1'b0;
    logic        rd_rsp_err = 1'b0;
    logic [15:0] rd_rsp_data = '0;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic        smp_last;
    logic        overrun;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cap_reader i_cap_reader (
        .clk(clk), .rst(rst), .trig(trig), .ch_en(ch_en),
        .rd_req_valid(rd_req_valid), .rd_addr(rd_addr), .rd_capture(rd_capture),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_err(rd_rsp_err), .rd_rsp_data(rd_rsp_data),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_last(smp_last),
        .overrun(overrun)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    string ptag = "R8";

    // reference model state
    int          m_st = 0;        // 0 idle, 1 request, 2 waiting, 3 streaming
    int          pend_q[$];
    logic [15:0] got_q[$];
    bit          m_first = 0;
    bit          m_ovr = 0;

    // responder state
    int lat = 1;
    int cd = -1;
    int rsp_ch = 0;
    int err_ch = -1;
    int burst_no = 0;
    bit stray = 0;

    function automatic logic [15:0] sval(int ch);
        return 16'(ch * 4663 + burst_no * 911 + 32769);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (%s) at cycle %0d: actual %0h expected %0h", tag, ptag, cycles, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic model_update();
        if (rst) begin
            m_st = 0; pend_q.delete(); got_q.delete(); m_first = 0; m_ovr = 0;
            return;
        end
        m_ovr = trig && (m_st != 0);
        case (m_st)
            0: if (trig) begin
                pend_q.delete(); got_q.delete();
                for (int i = 0; i < 7; i++) if (ch_en[i]) pend_q.push_back(i);
                if (pend_q.size() != 0) begin m_st = 1; m_first = 1; end
            end
            1: m_st = 2;
            2: if (rd_rsp_valid) begin
                if (rd_rsp_err) m_st = 0;
                else begin
                    got_q.push_back(rd_rsp_data);
                    void'(pend_q.pop_front());
                    m_first = 0;
                    m_st = (pend_q.size() == 0) ? 3 : 1;
                end
            end
            default: begin
                void'(got_q.pop_front());
                if (got_q.size() == 0) m_st = 0;
            end
        endcase
    endtask

    task automatic compare();
        bit er = (m_st == 1);
        bit es = (m_st == 3);
        chk(rd_req_valid === er, "R1 req", 32'(rd_req_valid), 32'(er));
        if (er) begin
            chk(rd_addr === 8'(8'h17 + pend_q[0]), "R2 addr", 32'(rd_addr), 32'(8'h17 + pend_q[0]));
            chk(rd_capture === m_first, "R3 capture", 32'(rd_capture), 32'(m_first));
        end
        chk(smp_valid === es, "R4 valid", 32'(smp_valid), 32'(es));
        if (es) begin
            chk(smp_data === got_q[0], "R4 data", 32'(smp_data), 32'(got_q[0]));
            chk(smp_last === (got_q.size() == 1), "R4 last", 32'(smp_last), 32'(got_q.size() == 1));
        end else begin
            chk(smp_last === 1'b0, "R4 last idle", 32'(smp_last), 0);
        end
        chk(overrun === m_ovr, "R7 overrun", 32'(overrun), 32'(m_ovr));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_update();
        @(negedge clk);
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            summary_and_end();
        end
        compare();
        rd_rsp_valid = 1'b0; rd_rsp_err = 1'b0;
        if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_err   = (rsp_ch == err_ch);
                rd_rsp_data  = sval(rsp_ch);
                cd = -1;
            end
        end
        if (rd_req_valid) begin
            rsp_ch = int'(rd_addr) - 'h17;
            cd = lat;
        end
        if (stray) begin
            rd_rsp_valid = 1'b1; rd_rsp_data = 16'hDEAD; stray = 0;
        end
    endtask

    task automatic run(int n);
        repeat (n) cycle();
    endtask

    task automatic fire(logic [6:0] m);
        ch_en = m; trig = 1'b1; burst_no++;
        cycle();
        trig = 1'b0;
    endtask

    initial begin
        ptag = "R8 reset";
        run(3);
        rst = 1'b0;
        run(2);

        ptag = "R1 full mask";   lat = 1; fire(7'h7F); run(25);
        ptag = "R1 sparse";      lat = 3; fire(7'h55); run(30);
        ptag = "R4 single gyro"; lat = 2; fire(7'h40); run(10);
        ptag = "R4 single temp"; lat = 1; fire(7'h01); run(8);
        ptag = "R6 zero mask";   fire(7'h00); run(5);
        ptag = "R6 zero then full"; fire(7'h00); fire(7'h0E); run(15);

        ptag = "R5 error mid";   err_ch = 3; lat = 2; fire(7'h7F); run(30);
        ptag = "R5 error first"; err_ch = 0; fire(7'h03); run(12);
        err_ch = -1;
        ptag = "R5 recovery";    fire(7'h7F); run(30);

        ptag = "R7 while waiting"; lat = 3; fire(7'h7F); run(2); fire(7'h01); run(4); fire(7'h7F);
        for (int k = 0; k < 60 && !smp_valid; k++) cycle();
        ptag = "R7 while streaming"; fire(7'h7F); run(12);

        ptag = "R9 stray idle";  stray = 1; run(3); stray = 1; run(3);
        fire(7'h30); run(15);

        ptag = "R1 random";
        for (int it = 0; it < 12; it++) begin
            lat = $urandom_range(1, 4);
            err_ch = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 6) : -1;
            fire(7'($urandom_range(0, 127)));
            run(45);
        end
        err_ch = -1;
        summary_and_end();
    end
endmodule